// File: doc/BRIEF.md
# Ethernet PHY Management Control Register File

This block is the register set that a single Ethernet PHY port shows to its management front end. A serial management receiver drives it over a parallel register-access port, which carries a 5-bit register address, 16-bit write data, a write strobe and a read strobe. Register 0 is the control word. Registers 1 to 6 return fixed identification and capability values that are set by parameters.

The control word drives the port's operating levels: loopback, power down, isolate, speed and duplex. It also raises one-clock pulses that request a soft reset or a restart of auto-negotiation. Speed, duplex and auto-negotiation enable are not plain storage. While auto-negotiation is on, speed and duplex show the negotiated result, which arrives on input pins. While auto-negotiation is off, software sets them. A fibre-mode strap forces the port to 100 Mb/s with auto-negotiation off. In fibre mode, duplex follows a separate strap pin.

Top module: `phy_ctrl_regs`

## Requirements
- R1: After hardware reset, register 0 holds its defaults: speed 1, auto-negotiation enable 1, duplex 1, and every other bit 0. It therefore reads 0x3100 when the negotiated inputs are both 1. Registers 1 to 6 read 0x0F49, 0x001C, 0xC883, 0x05E1, 0x0001 and 0x0000.
- R2: Writing register 0 with bit 15 set raises `soft_rst_pulse` for exactly the one clock after the write. It also restores every control bit to its R1 default, and the rest of that word is discarded. Bit 15 reads 1 during the pulse clock and 0 afterwards.
- R3: Writing register 0 with bit 9 set (and bit 15 clear) raises `an_restart_pulse` for exactly the one clock after the write. Bit 9 reads 1 during that clock and 0 afterwards.
- R4: Bit 14 is writable and reads back as written. `loopback_en` is high only when bit 14 is set and the effective speed is 10 Mb/s.
- R5: Bit 11 (power down) and bit 10 (isolate) are writable, read back as written, and drive `power_down` and `isolate` directly.
- R6: While auto-negotiation is enabled and fibre mode is off, bit 13 and `speed_100` equal `neg_speed_100`, and bit 8 and `full_duplex` equal `neg_full_duplex`. Values written to bits 13 and 8 are discarded.
- R7: A write to register 0 that clears bit 12 (fibre mode off) also stores bits 13 and 8. These bits then read back and drive `speed_100` and `full_duplex` regardless of the negotiated inputs.
- R8: With `fibre_mode` high, bit 12 reads 0 and bit 13 reads 1, and `speed_100` is 1. Writes to bits 13 and 12 are discarded, so the stored auto-negotiation enable reappears when fibre mode ends.
- R9: With `fibre_mode` high, bit 8 and `full_duplex` equal the value that `fibre_duplex` had at the previous clock edge.
- R10: Bits 7:0 of register 0 read 0. Addresses 7 to 31 read 0x0000. Writes to any address other than 0 change nothing.
- R11: `rd_data` shows the addressed register in the same cycle that `rd_en` is high, and is 0x0000 while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous hardware reset |
| reg_addr | input | 5 | Register address |
| wr_data | input | 16 | Write data |
| wr_en | input | 1 | Write strobe, one clock per write |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Read data, valid while rd_en is high |
| fibre_mode | input | 1 | Fibre-mode strap |
| fibre_duplex | input | 1 | Duplex strap used in fibre mode |
| neg_speed_100 | input | 1 | Negotiated speed, 1 = 100 Mb/s |
| neg_full_duplex | input | 1 | Negotiated duplex, 1 = full |
| soft_rst_pulse | output | 1 | One-clock soft reset request |
| an_restart_pulse | output | 1 | One-clock auto-negotiation restart request |
| loopback_en | output | 1 | Transmit-to-receive loopback active |
| power_down | output | 1 | Power-down level |
| isolate | output | 1 | MAC-side isolation level |
| speed_100 | output | 1 | Effective speed, 1 = 100 Mb/s |
| full_duplex | output | 1 | Effective duplex, 1 = full |

## Verification
The assertions check the following on every cycle:
- both command pulses last one clock and only follow a matching write;
- loopback never shows at 100 Mb/s, and fibre mode always forces 100 Mb/s;
- in fibre mode, duplex follows the strap with one clock of delay;
- power down holds still without a control write;
- unimplemented addresses and idle reads return zero.

Only the directed scenarios can show the rest:
- the full register values after hardware reset and after soft reset;
- that a write to the speed and duplex bits is discarded while auto-negotiation is on, yet taken when the same word turns it off;
- that the stored enable survives a period in fibre mode;
- that writes to read-only registers leave them unchanged.

// File: rtl/phy_ctrl_regs.sv
module phy_ctrl_regs #(
  parameter int          AW       = 5,
  parameter logic [15:0] ID_STAT  = 16'h0F49,
  parameter logic [15:0] ID_HI    = 16'h001C,
  parameter logic [15:0] ID_LO    = 16'hC883,
  parameter logic [15:0] ADV_VAL  = 16'h05E1,
  parameter logic [15:0] LPA_VAL  = 16'h0001,
  parameter logic [15:0] EXP_VAL  = 16'h0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic [15:0]   wr_data,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic [15:0]   rd_data,
  input  logic          fibre_mode,
  input  logic          fibre_duplex,
  input  logic          neg_speed_100,
  input  logic          neg_full_duplex,
  output logic          soft_rst_pulse,
  output logic          an_restart_pulse,
  output logic          loopback_en,
  output logic          power_down,
  output logic          isolate,
  output logic          speed_100,
  output logic          full_duplex
);

  logic lb_q, an_q, pd_q, iso_q, spd_q, dup_q;
  logic srst_q, rstrt_q, fdup_q;
  logic ctl_wr, eff_an;
  logic [15:0] ctl_word;

  assign ctl_wr = wr_en && (reg_addr == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lb_q <= 1'b0; an_q <= 1'b1; pd_q <= 1'b0;
      iso_q <= 1'b0; spd_q <= 1'b1; dup_q <= 1'b1;
      srst_q <= 1'b0; rstrt_q <= 1'b0; fdup_q <= 1'b0;
    end else begin
      srst_q  <= 1'b0;
      rstrt_q <= 1'b0;
      fdup_q  <= fibre_duplex;
      if (ctl_wr) begin
        if (wr_data[15]) begin
          lb_q <= 1'b0; an_q <= 1'b1; pd_q <= 1'b0;
          iso_q <= 1'b0; spd_q <= 1'b1; dup_q <= 1'b1;
          srst_q <= 1'b1;
        end else begin
          lb_q    <= wr_data[14];
          pd_q    <= wr_data[11];
          iso_q   <= wr_data[10];
          rstrt_q <= wr_data[9];
          if (!fibre_mode) begin
            an_q <= wr_data[12];
            if (!wr_data[12]) begin
              spd_q <= wr_data[13];
              dup_q <= wr_data[8];
            end
          end
        end
      end
    end
  end

  assign eff_an      = !fibre_mode && an_q;
  assign speed_100   = fibre_mode ? 1'b1   : (eff_an ? neg_speed_100   : spd_q);
  assign full_duplex = fibre_mode ? fdup_q : (eff_an ? neg_full_duplex : dup_q);

  assign soft_rst_pulse   = srst_q;
  assign an_restart_pulse = rstrt_q;
  assign loopback_en      = lb_q && !speed_100;
  assign power_down       = pd_q;
  assign isolate          = iso_q;

  assign ctl_word = {srst_q, lb_q, speed_100, eff_an, pd_q, iso_q,
                     rstrt_q, full_duplex, 8'h00};

  always_comb begin
    rd_data = 16'h0000;
    if (rd_en) begin
      case (reg_addr)
        AW'(0): rd_data = ctl_word;
        AW'(1): rd_data = ID_STAT;
        AW'(2): rd_data = ID_HI;
        AW'(3): rd_data = ID_LO;
        AW'(4): rd_data = ADV_VAL;
        AW'(5): rd_data = LPA_VAL;
        AW'(6): rd_data = EXP_VAL;
        default: rd_data = 16'h0000;
      endcase
    end
  end

endmodule

module phy_ctrl_regs_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] reg_addr,
  input logic [15:0]   wr_data,
  input logic          wr_en,
  input logic          rd_en,
  input logic [15:0]   rd_data,
  input logic          fibre_mode,
  input logic          fibre_duplex,
  input logic          soft_rst_pulse,
  input logic          an_restart_pulse,
  input logic          loopback_en,
  input logic          power_down,
  input logic          speed_100,
  input logic          full_duplex
);

  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_sr_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_pulse |=> !soft_rst_pulse);

  p_sr_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && soft_rst_pulse) |->
      $past(wr_en && reg_addr == '0 && wr_data[15]));

  p_rs_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    an_restart_pulse |=> !an_restart_pulse);

  p_rs_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && an_restart_pulse) |->
      $past(wr_en && reg_addr == '0 && wr_data[9] && !wr_data[15]));

  p_loop_10m_r4: assert property (@(posedge clk) disable iff (!rst_n)
    loopback_en |-> !speed_100);

  p_pd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !(wr_en && reg_addr == '0)) |=> $stable(power_down));

  p_fibre_spd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fibre_mode |-> speed_100);

  p_fibre_dup_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && fibre_mode) |-> full_duplex == $past(fibre_duplex));

  p_unimpl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_addr > AW'(6)) |-> rd_data == 16'h0000);

  p_idle_rd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rd_data == 16'h0000);

endmodule

bind phy_ctrl_regs phy_ctrl_regs_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_data(wr_data),
  .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
  .fibre_mode(fibre_mode), .fibre_duplex(fibre_duplex),
  .soft_rst_pulse(soft_rst_pulse), .an_restart_pulse(an_restart_pulse),
  .loopback_en(loopback_en), .power_down(power_down),
  .speed_100(speed_100), .full_duplex(full_duplex)
);

// File: tb/test_phy_ctrl_regs.sv
module test_phy_ctrl_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        fibre_mode = 1'b0, fibre_duplex = 1'b0;
  logic        neg_speed_100 = 1'b1, neg_full_duplex = 1'b1;
  logic        soft_rst_pulse, an_restart_pulse, loopback_en;
  logic        power_down, isolate, speed_100, full_duplex;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_ctrl_regs i_phy_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_data(wr_data),
    .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
    .fibre_mode(fibre_mode), .fibre_duplex(fibre_duplex),
    .neg_speed_100(neg_speed_100), .neg_full_duplex(neg_full_duplex),
    .soft_rst_pulse(soft_rst_pulse), .an_restart_pulse(an_restart_pulse),
    .loopback_en(loopback_en), .power_down(power_down), .isolate(isolate),
    .speed_100(speed_100), .full_duplex(full_duplex)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    reg_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [15:0] d);
    reg_addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    rd_en = 1'b0;
    #1;
  endtask

  task automatic rd_chk(string req, logic [4:0] a, logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 reg0", 5'd0, 16'h3100);
    rd_chk("R1 reg1", 5'd1, 16'h0F49);
    rd_chk("R1 reg2", 5'd2, 16'h001C);
    rd_chk("R1 reg3", 5'd3, 16'hC883);
    rd_chk("R1 reg4", 5'd4, 16'h05E1);
    rd_chk("R1 reg5", 5'd5, 16'h0001);
    rd_chk("R1 reg6", 5'd6, 16'h0000);
    check("R1 levels", {11'd0, loopback_en, power_down, isolate, speed_100, full_duplex}, 16'h0003);
    check("R1 pulses", {14'd0, soft_rst_pulse, an_restart_pulse}, 16'h0000);
  endtask

  task automatic t_an_follow;
    @(negedge clk); neg_speed_100 = 1'b0; neg_full_duplex = 1'b0;
    rd_chk("R6 follow neg", 5'd0, 16'h1000);
    wr(5'd0, 16'h3100);
    rd_chk("R6 write dropped", 5'd0, 16'h1000);
    check("R6 outputs", {14'd0, speed_100, full_duplex}, 16'h0000);
    neg_speed_100 = 1'b1; #1;
    check("R6 speed tracks", {15'd0, speed_100}, 16'h0001);
  endtask

  task automatic t_forced;
    wr(5'd0, 16'h0000);
    rd_chk("R7 forced 10 half", 5'd0, 16'h0000);
    check("R7 outputs 10 half", {14'd0, speed_100, full_duplex}, 16'h0000);
    wr(5'd0, 16'h2100);
    rd_chk("R7 forced 100 full", 5'd0, 16'h2100);
    neg_speed_100 = 1'b0; neg_full_duplex = 1'b0; #1;
    check("R7 ignores neg", {14'd0, speed_100, full_duplex}, 16'h0003);
  endtask

  task automatic t_loop;
    wr(5'd0, 16'h6100);
    rd_chk("R4 reads back", 5'd0, 16'h6100);
    check("R4 no loop at 100M", {15'd0, loopback_en}, 16'h0000);
    wr(5'd0, 16'h4000);
    check("R4 loop at 10M", {15'd0, loopback_en}, 16'h0001);
  endtask

  task automatic t_pd_iso;
    wr(5'd0, 16'h0C00);
    rd_chk("R5 reads back", 5'd0, 16'h0C00);
    check("R5 levels", {13'd0, power_down, isolate, loopback_en}, 16'h0006);
  endtask

  task automatic t_restart;
    wr(5'd0, 16'h1200);
    check("R3 pulse", {15'd0, an_restart_pulse}, 16'h0001);
    rd_chk("R3 bit9 during pulse", 5'd0, 16'h1200);
    @(negedge clk);
    check("R3 pulse ends", {15'd0, an_restart_pulse}, 16'h0000);
    rd_chk("R3 bit9 cleared", 5'd0, 16'h1000);
  endtask

  task automatic t_soft;
    wr(5'd0, 16'h4C00);
    neg_speed_100 = 1'b1; neg_full_duplex = 1'b1;
    wr(5'd0, 16'h8C00);
    check("R2 pulse", {15'd0, soft_rst_pulse}, 16'h0001);
    rd_chk("R2 bit15 during pulse", 5'd0, 16'hB100);
    @(negedge clk);
    check("R2 pulse ends", {15'd0, soft_rst_pulse}, 16'h0000);
    rd_chk("R2 defaults", 5'd0, 16'h3100);
    check("R2 levels", {13'd0, power_down, isolate, loopback_en}, 16'h0000);
  endtask

  task automatic t_fibre;
    @(negedge clk); fibre_mode = 1'b1; fibre_duplex = 1'b1;
    @(negedge clk);
    rd_chk("R8 fibre read", 5'd0, 16'h2100);
    check("R8 speed", {15'd0, speed_100}, 16'h0001);
    wr(5'd0, 16'h1000);
    rd_chk("R8 writes dropped", 5'd0, 16'h2100);
    fibre_duplex = 1'b0; #1;
    check("R9 strap lag", {15'd0, full_duplex}, 16'h0001);
    @(negedge clk);
    check("R9 strap tracked", {15'd0, full_duplex}, 16'h0000);
    rd_chk("R9 bit8 half", 5'd0, 16'h2000);
    fibre_mode = 1'b0; #1;
    rd_chk("R8 enable preserved", 5'd0, 16'h3100);
  endtask

  task automatic t_unimpl;
    logic [15:0] v;
    rd_chk("R10 addr7", 5'd7, 16'h0000);
    rd_chk("R10 addr31", 5'd31, 16'h0000);
    wr(5'd1, 16'hFFFF);
    wr(5'd20, 16'h0000);
    rd_chk("R10 reg1 kept", 5'd1, 16'h0F49);
    rd_chk("R10 reg0 kept", 5'd0, 16'h3100);
    wr(5'd0, 16'h00FF);
    rd_chk("R10 low bits zero", 5'd0, 16'h0000);
    reg_addr = 5'd1; rd_en = 1'b0; #1; v = rd_data;
    check("R11 idle read zero", v, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_an_follow;
    t_forced;
    t_loop;
    t_pd_iso;
    t_restart;
    t_soft;
    t_fibre;
    t_unimpl;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule